// File: doc/BRIEF.md
# Three-Level Page Table Walker

This block turns a 39-bit virtual address into a 56-bit physical address by reading page-table entries from memory one 64-bit word at a time. A requester presents a virtual address together with the current address-translation control word and privilege mode. When translation is active, the walker fetches an entry from the root table and then from up to two lower tables. It stops as soon as it meets a leaf entry, and it reports either a physical address or a fault.

A leaf found at the top level maps a 1 GiB region and a leaf found at the middle level maps a 2 MiB region. In both cases the virtual index fields below the leaf's level pass straight into the physical address. When translation is off the address comes back unchanged after one cycle, and memory is not touched. Memory reads use a one-cycle request pulse with an address, followed by a response strobe that may arrive any number of cycles later.

Top module: `page_walker`

## Requirements
- R1: While `rst_n` is low, `done`, `fault`, `mem_req` and `paddr` are all 0.
- R2: Translation runs only when `satp[63]` is 1 and `priv_mode` is not 2'b11. Otherwise an accepted request finishes with `paddr` = `req_vaddr[55:0]` zero-extended, `fault` = 0, and no `mem_req`.
- R3: The first read address is `(satp[43:0] << 12) + 8*vaddr[38:30]`. A non-leaf entry makes the next read `(pte[53:10] << 12) + 8*idx`, where idx is `vaddr[29:21]` at the middle level and `vaddr[20:12]` at the bottom level.
- R4: An entry is a leaf when bit 1 or bit 3 is set. A valid non-leaf entry descends one level, so one walk makes at most three reads.
- R5: A leaf at the top level gives `paddr` = `{pte[53:28], vaddr[29:0]}`, whatever the value of `pte[27:10]`.
- R6: A leaf at the middle level gives `paddr` = `{pte[53:19], vaddr[20:0]}`.
- R7: A leaf at the bottom level gives `paddr` = `{pte[53:10], vaddr[11:0]}`.
- R8: An entry with bit 0 clear ends the walk with a fault. This check comes before the leaf test. A valid non-leaf entry at the bottom level also ends the walk with a fault. On a fault `paddr` is 0.
- R9: Each read raises `mem_req` for exactly one cycle and then waits for `mem_rvalid` for as many cycles as it takes. A `mem_rvalid` that arrives while no read is outstanding has no effect.
- R10: `req_valid` is accepted only when the walker is idle. A request presented during a walk is dropped.
- R11: `done` is high for exactly one cycle per request. `paddr` and `fault` keep their values until the next result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Translation request |
| req_vaddr | input | 64 | Virtual address (bits 38:0 translated) |
| satp | input | 64 | Translation control: bit 63 enable, bits 43:0 root page number |
| priv_mode | input | 2 | Current privilege, 2'b11 = machine |
| mem_req | output | 1 | One-cycle read request |
| mem_addr | output | 56 | Byte address of the entry being read |
| mem_rvalid | input | 1 | Read data strobe |
| mem_rdata | input | 64 | Entry read from memory |
| done | output | 1 | Result strobe |
| fault | output | 1 | Walk failed |
| paddr | output | 64 | Zero-extended physical address |

## Verification
The hardest case to reach is the fault raised by a valid pointer entry at the bottom level. It only happens after two valid non-leaf reads, so the bench builds a dedicated chain of tables ending in such an entry. A further hard case is a late or stray response strobe. The memory model delays each response by a latency that changes from vector to vector. A separate injector raises `mem_rvalid` while the walker is idle, and the bench holds `req_valid` high during a long walk. Both must leave the result untouched.

// File: rtl/pw_pkg.sv
package pw_pkg;
  localparam int XLEN      = 64;
  localparam int PA_W      = 56;
  localparam int VA_W      = 39;
  localparam int PG_OFF    = 12;
  localparam int IDX_W     = 9;
  localparam int LEVELS    = 3;
  localparam int PTE_LG    = 3;
  localparam int PPN_LSB   = 10;
  localparam int PPN_W     = PA_W - PG_OFF;
  localparam int LVL_W     = $clog2(LEVELS);
  localparam int SATP_MODE = 63;
  localparam int BIT_V     = 0;
  localparam int BIT_R     = 1;
  localparam int BIT_X     = 3;
  localparam logic [1:0] PRIV_MACH = 2'b11;

  typedef enum logic [1:0] {
    PW_IDLE = 2'd0,
    PW_REQ  = 2'd1,
    PW_WAIT = 2'd2,
    PW_DONE = 2'd3
  } pw_state_e;
endpackage

// File: rtl/pw_index_sel.sv
module pw_index_sel #(
  parameter int VA_W   = pw_pkg::VA_W,
  parameter int PG_OFF = pw_pkg::PG_OFF,
  parameter int IDX_W  = pw_pkg::IDX_W,
  parameter int LEVELS = pw_pkg::LEVELS,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  output logic [IDX_W-1:0] idx
);
  logic [IDX_W-1:0] fld [LEVELS];
  logic             unused_off;

  for (genvar g = 0; g < LEVELS; g++) begin : g_fld
    assign fld[g] = va[PG_OFF + IDX_W*g +: IDX_W];
  end

  assign unused_off = ^va[PG_OFF-1:0];

  always_comb begin
    idx = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) idx = fld[i];
    end
  end
endmodule

// File: rtl/pw_pte_dec.sv
module pw_pte_dec #(
  parameter int XLEN    = pw_pkg::XLEN,
  parameter int PA_W    = pw_pkg::PA_W,
  parameter int PG_OFF  = pw_pkg::PG_OFF,
  parameter int PPN_LSB = pw_pkg::PPN_LSB,
  localparam int PPN_W  = PA_W - PG_OFF
) (
  input  logic [XLEN-1:0]  pte,
  output logic             valid,
  output logic             leaf,
  output logic [PPN_W-1:0] ppn,
  output logic [PA_W-1:0]  next_base
);
  logic unused_bits;

  assign valid     = pte[pw_pkg::BIT_V];
  assign leaf      = pte[pw_pkg::BIT_R] | pte[pw_pkg::BIT_X];
  assign ppn       = pte[PPN_LSB +: PPN_W];
  assign next_base = {ppn, {PG_OFF{1'b0}}};

  assign unused_bits = ^{pte[XLEN-1:PPN_LSB+PPN_W], pte[PPN_LSB-1:pw_pkg::BIT_X+1], pte[2]};
endmodule

// File: rtl/pw_pa_form.sv
module pw_pa_form #(
  parameter int VA_W   = pw_pkg::VA_W,
  parameter int PA_W   = pw_pkg::PA_W,
  parameter int PG_OFF = pw_pkg::PG_OFF,
  parameter int IDX_W  = pw_pkg::IDX_W,
  parameter int LEVELS = pw_pkg::LEVELS,
  localparam int PPN_W = PA_W - PG_OFF,
  localparam int LVL_W = $clog2(LEVELS)
) (
  input  logic [PPN_W-1:0] ppn,
  input  logic [VA_W-1:0]  va,
  input  logic [LVL_W-1:0] level,
  output logic [PA_W-1:0]  pa
);
  localparam int TOP_KEEP = PG_OFF + IDX_W*(LEVELS-1);

  logic [PA_W-1:0] cand [LEVELS];
  logic            unused_hi;

  // A leaf at level g keeps the lowest PG_OFF + g*IDX_W address bits from the
  // virtual address; the page number supplies only the bits above them.
  for (genvar g = 0; g < LEVELS; g++) begin : g_cand
    localparam int KEEP = PG_OFF + IDX_W*g;
    assign cand[g] = {ppn[PPN_W-1:KEEP-PG_OFF], va[KEEP-1:0]};
  end

  assign unused_hi = ^va[VA_W-1:TOP_KEEP];

  always_comb begin
    pa = '0;
    for (int i = 0; i < LEVELS; i++) begin
      if (level == LVL_W'(i)) pa = cand[i];
    end
  end
endmodule

// File: rtl/page_walker.sv
module page_walker
  import pw_pkg::*;
#(
  parameter int XLEN_P   = XLEN,
  parameter int PA_W_P   = PA_W,
  parameter int VA_W_P   = VA_W,
  parameter int LEVELS_P = LEVELS,
  localparam int PPN_W_P = PA_W_P - PG_OFF,
  localparam int LVL_W_P = $clog2(LEVELS_P)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  input  logic [XLEN_P-1:0] req_vaddr,
  input  logic [XLEN_P-1:0] satp,
  input  logic [1:0]        priv_mode,
  output logic              mem_req,
  output logic [PA_W_P-1:0] mem_addr,
  input  logic              mem_rvalid,
  input  logic [XLEN_P-1:0] mem_rdata,
  output logic              done,
  output logic              fault,
  output logic [XLEN_P-1:0] paddr
);
  pw_state_e            state_q, state_d;
  logic [LVL_W_P-1:0]   level_q, level_d;
  logic [PA_W_P-1:0]    base_q, base_d;
  logic [VA_W_P-1:0]    va_q;
  logic [PA_W_P-1:0]    pa_q, pa_d;
  logic                 fault_q, fault_d;
  logic                 accept, step, res_en;
  logic                 xlate_on;
  logic [IDX_W-1:0]     idx;
  logic                 pte_v, pte_leaf;
  logic [PPN_W_P-1:0]   pte_ppn;
  logic [PA_W_P-1:0]    pte_next;
  logic [PA_W_P-1:0]    leaf_pa;
  logic                 unused_in;

  assign unused_in = ^{req_vaddr[XLEN_P-1:PA_W_P], satp[SATP_MODE-1:PPN_W_P]};

  pw_index_sel #(.VA_W(VA_W_P), .PG_OFF(PG_OFF), .IDX_W(IDX_W), .LEVELS(LEVELS_P)) u_idx (
    .va(va_q), .level(level_q), .idx(idx)
  );

  pw_pte_dec #(.XLEN(XLEN_P), .PA_W(PA_W_P), .PG_OFF(PG_OFF), .PPN_LSB(PPN_LSB)) u_dec (
    .pte(mem_rdata), .valid(pte_v), .leaf(pte_leaf), .ppn(pte_ppn), .next_base(pte_next)
  );

  pw_pa_form #(.VA_W(VA_W_P), .PA_W(PA_W_P), .PG_OFF(PG_OFF), .IDX_W(IDX_W),
               .LEVELS(LEVELS_P)) u_pa (
    .ppn(pte_ppn), .va(va_q), .level(level_q), .pa(leaf_pa)
  );

  assign xlate_on = satp[SATP_MODE] & (priv_mode != PRIV_MACH);
  assign accept   = (state_q == PW_IDLE) & req_valid;
  assign step     = (state_q == PW_WAIT) & mem_rvalid;

  always_comb begin
    state_d = state_q;
    level_d = level_q;
    base_d  = base_q;
    pa_d    = pa_q;
    fault_d = fault_q;
    res_en  = 1'b0;
    unique case (state_q)
      PW_IDLE: begin
        if (req_valid) begin
          if (xlate_on) begin
            base_d  = {satp[PPN_W_P-1:0], {PG_OFF{1'b0}}};
            level_d = LVL_W_P'(LEVELS_P-1);
            state_d = PW_REQ;
          end else begin
            pa_d    = req_vaddr[PA_W_P-1:0];
            fault_d = 1'b0;
            res_en  = 1'b1;
            state_d = PW_DONE;
          end
        end
      end
      PW_REQ: state_d = PW_WAIT;
      PW_WAIT: begin
        if (mem_rvalid) begin
          if (!pte_v || (!pte_leaf && level_q == '0)) begin
            pa_d    = '0;
            fault_d = 1'b1;
            res_en  = 1'b1;
            state_d = PW_DONE;
          end else if (pte_leaf) begin
            pa_d    = leaf_pa;
            fault_d = 1'b0;
            res_en  = 1'b1;
            state_d = PW_DONE;
          end else begin
            base_d  = pte_next;
            level_d = level_q - 1'b1;
            state_d = PW_REQ;
          end
        end
      end
      PW_DONE: state_d = PW_IDLE;
      default: state_d = PW_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= PW_IDLE;
      level_q <= '0;
      base_q  <= '0;
      va_q    <= '0;
      pa_q    <= '0;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      if (accept) va_q <= req_vaddr[VA_W_P-1:0];
      if (accept || step) begin
        level_q <= level_d;
        base_q  <= base_d;
      end
      if (res_en) begin
        pa_q    <= pa_d;
        fault_q <= fault_d;
      end
    end
  end

  assign mem_req  = (state_q == PW_REQ);
  assign mem_addr = base_q + {{(PA_W_P-IDX_W-PTE_LG){1'b0}}, idx, {PTE_LG{1'b0}}};
  assign done     = (state_q == PW_DONE);
  assign fault    = fault_q;
  assign paddr    = {{(XLEN_P-PA_W_P){1'b0}}, pa_q};

  AST_REQ_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req); // R9
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R11
  AST_FAULT_NO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    fault |-> (paddr == '0)); // R8
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(paddr) || !$stable(fault)) |-> done); // R11
  AST_ADDR_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[PTE_LG-1:0] == '0)); // R3
  AST_LEVEL_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    level_q <= LVL_W_P'(LEVELS_P-1)); // R4
  AST_NO_REQ_WHEN_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !mem_req); // R9
endmodule

// File: tb/page_walker_tb_top.sv
module page_walker_tb_top;
  typedef struct packed {
    logic [63:0] satp;
    logic [1:0]  priv;
    logic [63:0] va;
    logic [63:0] pa;
    logic        flt;
    logic [3:0]  nrd;
    logic [1:0]  lat;
  } vec_t;

  localparam logic [63:0] S_ON  = 64'h8000_0000_0000_0100;
  localparam logic [63:0] S_OFF = 64'h0000_0000_0000_0100;
  localparam int NV = 10;
  localparam vec_t VECS [NV] = '{
    '{S_ON,  2'b01, 64'h0000_0000_557C_D123, 64'h0000_0000_D57C_D123, 1'b0, 4'd1, 2'd0}, // R5
    '{S_ON,  2'b00, 64'h0000_0000_80AF_FABC, 64'h0000_0000_802F_FABC, 1'b0, 4'd2, 2'd1}, // R6
    '{S_ON,  2'b01, 64'h0000_0000_80C0_97FF, 64'h0000_0000_1234_57FF, 1'b0, 4'd3, 2'd2}, // R7
    '{S_ON,  2'b01, 64'h0000_0000_80C0_A000, 64'h0000_0000_ABCD_E000, 1'b0, 4'd3, 2'd3}, // R7
    '{S_ON,  2'b01, 64'h0000_0000_C000_0010, 64'h0,                   1'b1, 4'd1, 2'd1}, // R8
    '{S_ON,  2'b01, 64'h0000_0000_80E0_4000, 64'h0,                   1'b1, 4'd3, 2'd0}, // R8
    '{S_ON,  2'b01, 64'h0000_0001_3FFF_FFFF, 64'h0000_0000_FFFF_FFFF, 1'b0, 4'd1, 2'd2}, // R5
    '{S_OFF, 2'b01, 64'hFF00_0000_1234_5678, 64'h0000_0000_1234_5678, 1'b0, 4'd0, 2'd0}, // R2
    '{S_ON,  2'b11, 64'h0000_0000_557C_D123, 64'h0000_0000_557C_D123, 1'b0, 4'd0, 2'd0}, // R2
    '{S_ON,  2'b01, 64'h0000_0001_4000_0000, 64'h0,                   1'b1, 4'd1, 2'd1}  // R8
  };

  logic        clk = 1'b0;
  logic        rst_n;
  logic        req_valid;
  logic [63:0] req_vaddr, satp;
  logic [1:0]  priv_mode;
  logic        mem_req;
  logic [55:0] mem_addr;
  logic        mem_rvalid;
  logic        mdl_rvalid, spur_rvalid;
  logic [63:0] mem_rdata;
  logic        done, fault;
  logic [63:0] paddr;

  int n_chk = 0;
  int n_fail = 0;
  int reads = 0;
  int lat_sel = 0;
  int cyc = 0;
  logic [55:0] addr_log [4];
  logic [63:0] pt_mem [logic [55:0]];
  logic        pend = 1'b0;
  int          cnt = 0;
  logic [55:0] pend_addr;

  always #5 clk = ~clk;

  assign mem_rvalid = mdl_rvalid | spur_rvalid;

  page_walker dut_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_vaddr(req_vaddr),
    .satp(satp), .priv_mode(priv_mode), .mem_req(mem_req), .mem_addr(mem_addr),
    .mem_rvalid(mem_rvalid), .mem_rdata(mem_rdata), .done(done), .fault(fault),
    .paddr(paddr)
  );

  // memory model: responds lat_sel cycles after the request, driven at negedge
  always @(negedge clk) begin
    mdl_rvalid = 1'b0;
    if (!rst_n) begin
      pend = 1'b0;
    end else begin
      if (pend) begin
        if (cnt == 0) begin
          mdl_rvalid = 1'b1;
          mem_rdata  = pt_mem.exists(pend_addr) ? pt_mem[pend_addr] : 64'd0;
          pend       = 1'b0;
        end else begin
          cnt = cnt - 1;
        end
      end
      if (mem_req) begin
        pend      = 1'b1;
        cnt       = lat_sel;
        pend_addr = mem_addr;
        if (reads < 4) addr_log[reads] = mem_addr;
        reads = reads + 1;
      end
    end
  end

  always @(posedge clk) begin
    cyc = cyc + 1;
    if (cyc > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL watchdog: run hung, actual cycles %0d expected below 100000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  task automatic chk(input logic ok, input string req, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    n_chk = n_chk + 1;
    if (!ok) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic string tag_of(input int i);
    case (i)
      0, 6:    return "R5";
      1:       return "R6";
      2, 3:    return "R7";
      7, 8:    return "R2";
      default: return "R8";
    endcase
  endfunction

  task automatic walk(input vec_t v, output logic got, output logic [63:0] pa,
                      output logic f);
    lat_sel = int'(v.lat);
    reads   = 0;
    got     = 1'b0;
    pa      = '0;
    f       = 1'b0;
    @(negedge clk);
    req_valid = 1'b1;
    req_vaddr = v.va;
    satp      = v.satp;
    priv_mode = v.priv;
    for (int k = 0; k < 200 && !got; k++) begin
      @(negedge clk);
      req_valid = 1'b0;
      if (done) begin
        got = 1'b1;
        pa  = paddr;
        f   = fault;
      end
    end
  endtask

  initial begin
    logic        got;
    logic [63:0] pa;
    logic        f;
    logic        seen;

    pt_mem[56'h100008] = 64'h8000_0000_3000_000F;
    pt_mem[56'h100010] = 64'h0000_0000_0004_0401;
    pt_mem[56'h100020] = 64'h0000_0000_3007_FC03;
    pt_mem[56'h100028] = 64'h0000_0000_0000_0002;
    pt_mem[56'h101028] = 64'h0000_0000_2008_000B;
    pt_mem[56'h101030] = 64'h0000_0000_0004_0801;
    pt_mem[56'h101038] = 64'h0000_0000_0004_0C01;
    pt_mem[56'h102048] = 64'h0000_0000_048D_1409;
    pt_mem[56'h102050] = 64'h0000_0000_2AF3_7803;
    pt_mem[56'h103020] = 64'h0000_0000_0015_5401;

    rst_n = 1'b0; req_valid = 1'b0; req_vaddr = '0; satp = '0; priv_mode = 2'b01;
    spur_rvalid = 1'b0; mem_rdata = '0; mdl_rvalid = 1'b0;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(!done && !fault && !mem_req && paddr == 0, "R1", "outputs in reset",
        {61'd0, done, fault, mem_req}, 64'd0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    // table of vectors
    for (int i = 0; i < NV; i++) begin
      walk(VECS[i], got, pa, f);
      chk(got, "R11", $sformatf("done seen row %0d", i), {63'd0, got}, 64'd1);
      chk(pa == VECS[i].pa, tag_of(i), $sformatf("paddr row %0d", i), pa, VECS[i].pa);
      chk(f == VECS[i].flt, tag_of(i), $sformatf("fault row %0d", i), {63'd0, f},
          {63'd0, VECS[i].flt});
      chk(reads == int'(VECS[i].nrd), (i == 7 || i == 8) ? "R2" : "R4",
          $sformatf("read count row %0d", i), 64'(reads), 64'(VECS[i].nrd));
    end

    // R3 read addresses of a full three-level walk
    walk(VECS[2], got, pa, f);
    chk(addr_log[0] == 56'h100010, "R3", "root entry address", 64'(addr_log[0]), 64'h100010);
    chk(addr_log[1] == 56'h101030, "R3", "middle entry address", 64'(addr_log[1]), 64'h101030);
    chk(addr_log[2] == 56'h102048, "R3", "bottom entry address", 64'(addr_log[2]), 64'h102048);

    // R11 result holds after done
    repeat (5) @(negedge clk);
    chk(!done && paddr == 64'h1234_57FF && !fault, "R11", "result held",
        paddr, 64'h1234_57FF);

    // R9 stray response strobe while idle has no effect
    mem_rdata   = 64'h0000_0000_3000_000F;
    spur_rvalid = 1'b1;
    @(negedge clk);
    spur_rvalid = 1'b0;
    seen = 1'b0;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(!seen && paddr == 64'h1234_57FF && !mem_req, "R9", "stray strobe ignored",
        paddr, 64'h1234_57FF);

    // R10 request held during a walk is dropped
    lat_sel = 3;
    reads   = 0;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = VECS[2].va; satp = S_ON; priv_mode = 2'b01;
    @(negedge clk);
    req_vaddr = VECS[0].va;
    repeat (3) @(negedge clk);
    req_valid = 1'b0;
    got = 1'b0;
    for (int k = 0; k < 200 && !got; k++) begin
      if (done) begin
        got = 1'b1;
        pa  = paddr;
      end else begin
        @(negedge clk);
      end
    end
    chk(got && pa == 64'h1234_57FF, "R10", "busy request ignored", pa, 64'h1234_57FF);
    seen = 1'b0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    chk(!seen && reads == 3, "R10", "no second walk", 64'(reads), 64'd3);

    // R1 reset in the middle of a walk
    lat_sel = 3;
    @(negedge clk);
    req_valid = 1'b1; req_vaddr = VECS[1].va;
    @(negedge clk);
    req_valid = 1'b0;
    repeat (2) @(negedge clk);
    rst_n = 1'b0;
    #1;
    chk(!done && !fault && !mem_req && paddr == 0, "R1", "outputs after mid-walk reset",
        paddr, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;
    repeat (10) @(negedge clk);
    walk(VECS[0], got, pa, f);
    chk(got && pa == VECS[0].pa && !f, "R5", "walk after reset", pa, VECS[0].pa);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule